// File: doc/BRIEF.md
# Decode-Stage Byte Consumption Controller

This block sits in the decode state of a processor whose instructions arrive through a byte-wide prefetch queue. On every clock spent in decode it decides whether the instruction at the head of the queue may be decoded now. If it may, the block retires that instruction's bytes. The program counter and the queue read pointer each advance by the instruction length, and the available-byte count drops by the same amount. All three updates happen on the same clock edge and come from one consumed-bytes value.

The instruction length comes from the column field of the head opcode, because all opcodes in a column share one length. Decode is refused in four cases: the sequencer is not in decode, the core is in a low-power state, the queue holds fewer bytes than the instruction needs, or debug mode is on with no single-step command pending. In debug mode each step command lets exactly one instruction through and is acknowledged in the cycle that instruction retires. The block also keeps the available-byte count, adding the bytes that the fetch side writes into the queue.

Top module: `byte_retire_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state is `pc` = `RESET_PC`, `rd_ptr` = 0, `avail` = 0 and no pending step. `decode_en` is 0 whenever `avail` is 0.
- R2: `instr_len` is decoded from `op_column` as follows: columns 0x0 to 0x5 give 2 bytes, 0x6 to 0x9 give 3, 0xA and 0xB give 4, and 0xC to 0xF give 1.
- R3: `decode_en` is 1 only when `avail` >= `instr_len`. With every other condition met, a shortfall of bytes holds decode off.
- R4: While `low_power` is 1, `decode_en` is 0.
- R5: While `dbg_mode` is 1, decode needs a step pending. A `step_cmd` pulse arms a pending step from the next cycle on. Decode then lets exactly one instruction through and drops the pending step, unless `step_cmd` is high in that same cycle. `step_ack` is 1 exactly in the cycle an instruction retires in debug mode.
- R6: A `step_cmd` given while `dbg_mode` is 0 leaves nothing pending. After debug mode is entered, no decode happens until a fresh command arrives.
- R7: When `decode_en` is 1, `used_bytes` equals `instr_len`. On the next edge, `pc` grows by `instr_len` (modulo 2^PC_W) and `avail` becomes `avail + push_bytes - instr_len`.
- R8: When `decode_en` is 0, `used_bytes` is 0, `pc` and `rd_ptr` keep their values, and `avail` becomes `avail + push_bytes`.
- R9: `rd_ptr` advances by `instr_len` modulo `DEPTH` and always stays below `DEPTH`.
- R10: While `at_decode` is 0, `decode_en` and `step_ack` are 0 and no bytes are consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| at_decode | input | 1 | Sequencer is in its decode state this cycle |
| op_column | input | 4 | Column field of the head opcode byte |
| push_bytes | input | CNT_W | Bytes the fetch side writes into the queue this cycle |
| low_power | input | 1 | Core is in a low-power state |
| dbg_mode | input | 1 | Debug halt mode active |
| step_cmd | input | 1 | Single-step command pulse |
| decode_en | output | 1 | Head instruction is decoded and retired this cycle |
| instr_len | output | LEN_W | Length of the head instruction in bytes |
| used_bytes | output | LEN_W | Bytes consumed this cycle (0 when blocked) |
| step_ack | output | 1 | A single step was taken this cycle |
| pc | output | PC_W | Program counter |
| rd_ptr | output | PTR_W | Prefetch-queue read pointer |
| avail | output | CNT_W | Bytes available in the queue |

## Verification
On every cycle the assertions check the decode gating: no decode in low power, outside the decode state, or with too few bytes. They also check that one debug decode without a fresh command is never followed by a second, that the counters hold when decode is blocked and move by the instruction length when it fires, and that the pointer and byte count stay in range. Only the bench scenarios can show the things that need history or a chosen sequence. These are the column-to-length table, a step command ignored outside debug mode, the pointer wrapping at the queue end, and the running byte count as fill and drain interleave.

// File: rtl/brc_pkg.sv
// Package: shared constants and types for the byte consumption controller.
// Assumes instructions are 1 to MAX_LEN bytes long.
package brc_pkg;

    localparam int MAX_LEN = 4;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);

    // Reason decode is or is not allowed this cycle, in priority order.
    typedef enum logic [2:0] {
        GT_IDLE    = 3'd0,   // sequencer not in decode
        GT_SLEEP   = 3'd1,   // low-power state
        GT_HALT    = 3'd2,   // debug mode, no step pending
        GT_STARVED = 3'd3,   // not enough bytes in the queue
        GT_GO      = 3'd4    // instruction retires this cycle
    } gate_e;

endpackage

// File: rtl/brc_len_lookup.sv
// Module: maps the opcode column to an instruction length.
// Assumes every opcode in a column has the same length.
module brc_len_lookup
    import brc_pkg::*;
(
    input  logic [3:0]       op_column,
    output logic [LEN_W-1:0] len
);

    // Purpose: range decode of the column into a byte length.
    always_comb begin
        if (op_column <= 4'h5)
            len = LEN_W'(2);
        else if (op_column <= 4'h9)
            len = LEN_W'(3);
        else if (op_column <= 4'hB)
            len = LEN_W'(4);
        else
            len = LEN_W'(1);
    end

endmodule

// File: rtl/brc_gate.sv
// Module: decides whether the head instruction may decode this cycle and
// keeps the pending single-step state. Assumes step_cmd is a pulse and
// that the sequencer holds at_decode high while waiting in decode.
module brc_gate
    import brc_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             at_decode,
    input  logic             low_power,
    input  logic             dbg_mode,
    input  logic             step_cmd,
    input  logic [CNT_W-1:0] avail,
    input  logic [LEN_W-1:0] len,
    output logic             fire,
    output logic             step_ack
);

    logic  step_pend;
    logic  enough;
    gate_e state;

    // Purpose: queue holds at least the bytes the instruction needs.
    always_comb enough = (avail >= CNT_W'(len));

    // Purpose: prioritised gate decision.
    always_comb begin
        if (!at_decode)
            state = GT_IDLE;
        else if (low_power)
            state = GT_SLEEP;
        else if (dbg_mode && !step_pend)
            state = GT_HALT;
        else if (!enough)
            state = GT_STARVED;
        else
            state = GT_GO;
    end

    // Purpose: drive the enable and the step acknowledge.
    always_comb begin
        fire     = (state == GT_GO);
        step_ack = fire && dbg_mode;
    end

    // Purpose: arm a step in debug mode, consume it when one instruction retires.
    always_ff @(posedge clk) begin
        if (!rst_n)
            step_pend <= 1'b0;
        else if (!dbg_mode)
            step_pend <= 1'b0;
        else if (fire)
            step_pend <= step_cmd;
        else
            step_pend <= step_pend | step_cmd;
    end

endmodule

// File: rtl/brc_retire.sv
// Module: applies one consumed-byte value to the program counter, the queue
// read pointer and the available-byte count on the same edge. Assumes the
// fetch side never pushes more bytes than the queue has room for.
module brc_retire
    import brc_pkg::*;
#(
    parameter int          PC_W     = 16,
    parameter int          DEPTH    = 8,
    parameter int          PTR_W    = 3,
    parameter int          CNT_W    = 4,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [LEN_W-1:0] len,
    input  logic [CNT_W-1:0] push_bytes,
    output logic [LEN_W-1:0] used_bytes,
    output logic [PC_W-1:0]  pc,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] avail
);

    localparam int               SUM_W   = PTR_W + LEN_W;
    localparam logic [SUM_W-1:0] DEPTH_S = SUM_W'(DEPTH);

    logic [SUM_W-1:0] ptr_sum;
    logic [PTR_W-1:0] ptr_next;
    logic [PC_W-1:0]  pc_next;
    logic [CNT_W-1:0] avail_next;

    // Purpose: consumed count defaults to zero and takes the length on decode.
    always_comb used_bytes = fire ? len : '0;

    // Purpose: read pointer advance with wrap at the queue depth.
    always_comb begin
        ptr_sum = SUM_W'(rd_ptr) + SUM_W'(used_bytes);
        if (ptr_sum >= DEPTH_S)
            ptr_next = PTR_W'(ptr_sum - DEPTH_S);
        else
            ptr_next = PTR_W'(ptr_sum);
    end

    // Purpose: program counter and byte count from the same consumed value.
    always_comb begin
        pc_next    = pc + PC_W'(used_bytes);
        avail_next = avail + push_bytes - CNT_W'(used_bytes);
    end

    // Purpose: register all three counters together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc     <= RESET_PC;
            rd_ptr <= '0;
            avail  <= '0;
        end else begin
            pc     <= pc_next;
            rd_ptr <= ptr_next;
            avail  <= avail_next;
        end
    end

endmodule

// File: rtl/byte_retire_ctrl.sv
// Module: top of the decode-stage byte consumption controller. Looks up the
// head instruction length, gates decode and retires the bytes consumed.
// Assumes DEPTH >= MAX_LEN and that push_bytes never overfills the queue.
module byte_retire_ctrl
    import brc_pkg::*;
#(
    parameter int              PC_W     = 16,
    parameter int              DEPTH    = 8,
    parameter int              PTR_W    = $clog2(DEPTH),
    parameter int              CNT_W    = $clog2(DEPTH + 1),
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             at_decode,
    input  logic [3:0]       op_column,
    input  logic [CNT_W-1:0] push_bytes,
    input  logic             low_power,
    input  logic             dbg_mode,
    input  logic             step_cmd,
    output logic             decode_en,
    output logic [LEN_W-1:0] instr_len,
    output logic [LEN_W-1:0] used_bytes,
    output logic             step_ack,
    output logic [PC_W-1:0]  pc,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] avail
);

    brc_len_lookup u_len (
        .op_column (op_column),
        .len       (instr_len)
    );

    brc_gate #(.CNT_W(CNT_W)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .at_decode (at_decode),
        .low_power (low_power),
        .dbg_mode  (dbg_mode),
        .step_cmd  (step_cmd),
        .avail     (avail),
        .len       (instr_len),
        .fire      (decode_en),
        .step_ack  (step_ack)
    );

    brc_retire #(
        .PC_W     (PC_W),
        .DEPTH    (DEPTH),
        .PTR_W    (PTR_W),
        .CNT_W    (CNT_W),
        .RESET_PC (RESET_PC)
    ) u_retire (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (decode_en),
        .len        (instr_len),
        .push_bytes (push_bytes),
        .used_bytes (used_bytes),
        .pc         (pc),
        .rd_ptr     (rd_ptr),
        .avail      (avail)
    );

endmodule

// File: rtl/brc_checker.sv
// Module: assertion checker bound to byte_retire_ctrl.
module brc_checker
    import brc_pkg::*;
#(
    parameter int              PC_W     = 16,
    parameter int              DEPTH    = 8,
    parameter int              PTR_W    = 3,
    parameter int              CNT_W    = 4,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             at_decode,
    input logic             low_power,
    input logic             dbg_mode,
    input logic             step_cmd,
    input logic             decode_en,
    input logic [LEN_W-1:0] instr_len,
    input logic [LEN_W-1:0] used_bytes,
    input logic             step_ack,
    input logic [PC_W-1:0]  pc,
    input logic [PTR_W-1:0] rd_ptr,
    input logic [CNT_W-1:0] avail
);

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (pc == RESET_PC && rd_ptr == '0 && avail == '0));

    p_enough_bytes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        decode_en |-> (avail >= CNT_W'(instr_len)));

    p_sleep_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        low_power |-> !decode_en);

    p_one_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_mode && decode_en && !step_cmd) |=> !(dbg_mode && decode_en));

    p_ack_in_debug_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step_ack |-> (decode_en && dbg_mode));

    p_pc_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
        decode_en |=> (pc == $past(pc) + PC_W'($past(instr_len))));

    p_avail_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        avail <= CNT_W'(DEPTH));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !decode_en |=> ($stable(pc) && $stable(rd_ptr)));

    p_ptr_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr < PTR_W'(DEPTH) || DEPTH == (1 << PTR_W));

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !at_decode |-> (!decode_en && used_bytes == '0 && !step_ack));

endmodule

bind byte_retire_ctrl brc_checker #(
    .PC_W     (PC_W),
    .DEPTH    (DEPTH),
    .PTR_W    (PTR_W),
    .CNT_W    (CNT_W),
    .RESET_PC (RESET_PC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .at_decode  (at_decode),
    .low_power  (low_power),
    .dbg_mode   (dbg_mode),
    .step_cmd   (step_cmd),
    .decode_en  (decode_en),
    .instr_len  (instr_len),
    .used_bytes (used_bytes),
    .step_ack   (step_ack),
    .pc         (pc),
    .rd_ptr     (rd_ptr),
    .avail      (avail)
);

// File: tb/byte_retire_ctrl_test.sv
`timescale 1ns/100ps
module byte_retire_ctrl_test;

    localparam int DEPTH = 8;
    localparam int PC_W  = 16;
    localparam int PTR_W = 3;
    localparam int CNT_W = 4;
    localparam int LEN_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             at_decode = 1'b0;
    logic [3:0]       op_column = 4'h0;
    logic [CNT_W-1:0] push_bytes = '0;
    logic             low_power = 1'b0;
    logic             dbg_mode = 1'b0;
    logic             step_cmd = 1'b0;
    logic             decode_en;
    logic [LEN_W-1:0] instr_len;
    logic [LEN_W-1:0] used_bytes;
    logic             step_ack;
    logic [PC_W-1:0]  pc;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] avail;

    byte_retire_ctrl #(.PC_W(PC_W), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .at_decode(at_decode), .op_column(op_column),
        .push_bytes(push_bytes), .low_power(low_power), .dbg_mode(dbg_mode),
        .step_cmd(step_cmd), .decode_en(decode_en), .instr_len(instr_len),
        .used_bytes(used_bytes), .step_ack(step_ack), .pc(pc), .rd_ptr(rd_ptr),
        .avail(avail)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int    pc;
        int    ptr;
        int    avail;
        string tag;
    } exp_t;

    exp_t sbq[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;

    // Reference model state, built from the requirements.
    int m_pc = 0, m_ptr = 0, m_avail = 0;
    bit m_pend = 1'b0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_len(input int col);
        if (col <= 5) return 2;
        if (col <= 9) return 3;
        if (col <= 11) return 4;
        return 1;
    endfunction

    // Driver: apply one cycle of stimulus, check combinational outputs,
    // push the expected registered state for the monitor.
    task automatic drive(input string tag, input bit ad, input int col, input int push_req,
                         input bit lp, input bit dbg, input bit stp);
        int  len;
        bit  fire;
        int  room;
        int  push;
        exp_t e;
        @(negedge clk);
        len  = exp_len(col);
        fire = ad && !lp && (!dbg || m_pend) && (m_avail >= len);
        room = DEPTH - m_avail + (fire ? len : 0);
        push = (push_req > room) ? room : push_req;
        at_decode  = ad;
        op_column  = 4'(col);
        push_bytes = CNT_W'(push);
        low_power  = lp;
        dbg_mode   = dbg;
        step_cmd   = stp;
        #1;
        chk("R2", "instr_len", int'(instr_len), len);
        chk(tag, "decode_en", int'(decode_en), int'(fire));
        chk(tag, "step_ack", int'(step_ack), int'(fire && dbg));
        chk(fire ? "R7" : "R8", "used_bytes", int'(used_bytes), fire ? len : 0);
        if (fire && (m_ptr + len >= DEPTH)) e.tag = "R9";
        else e.tag = fire ? "R7" : "R8";
        if (fire) begin
            m_pc  = (m_pc + len) % (1 << PC_W);
            m_ptr = (m_ptr + len) % DEPTH;
        end
        m_avail = m_avail + push - (fire ? len : 0);
        if (!dbg) m_pend = 1'b0;
        else if (fire) m_pend = stp;
        else m_pend = m_pend | stp;
        e.pc = m_pc; e.ptr = m_ptr; e.avail = m_avail;
        sbq.push_back(e);
    endtask

    // Monitor: compare registered outputs after each edge.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (sbq.size() > 0) begin
                e = sbq.pop_front();
                chk(e.tag, "pc", int'(pc), e.pc);
                chk(e.tag, "rd_ptr", int'(rd_ptr), e.ptr);
                chk(e.tag, "avail", int'(avail), e.avail);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        #100000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", "pc", int'(pc), 0);
        chk("R1", "rd_ptr", int'(rd_ptr), 0);
        chk("R1", "avail", int'(avail), 0);
        chk("R1", "decode_en", int'(decode_en), 0);

        // R10: outside decode, only filling happens
        drive("R10", 0, 1, 3, 0, 0, 0);
        drive("R10", 0, 1, 5, 0, 0, 0);
        // R2/R7: normal decodes
        drive("R7", 1, 1, 0, 0, 0, 0);
        drive("R2", 1, 7, 0, 0, 0, 0);
        // R3: shortfall of bytes
        drive("R3", 1, 10, 0, 0, 0, 0);
        // R9: wrap of the read pointer
        drive("R9", 1, 15, 2, 0, 0, 0);
        drive("R9", 1, 11, 4, 0, 0, 0);
        // R4: low power blocks
        drive("R4", 1, 12, 0, 1, 0, 0);
        // R5: debug stepping
        drive("R5", 1, 12, 0, 0, 1, 0);
        drive("R5", 1, 12, 0, 0, 1, 1);
        drive("R5", 1, 12, 0, 0, 1, 0);
        drive("R5", 1, 12, 0, 0, 1, 0);
        drive("R5", 1, 12, 0, 0, 1, 1);
        drive("R5", 1, 12, 0, 0, 1, 1);
        drive("R5", 1, 12, 0, 0, 1, 0);
        drive("R5", 1, 12, 0, 0, 1, 0);
        // R6: step outside debug is ignored
        drive("R6", 0, 12, 4, 0, 0, 1);
        drive("R6", 1, 12, 0, 0, 1, 0);
        drive("R6", 1, 12, 0, 0, 1, 0);
        // R8: blocked while filling
        drive("R8", 1, 12, 2, 1, 0, 0);
        // Mixed fill and drain over all columns
        for (int i = 0; i < 48; i++) begin
            drive("R7", 1, (i * 7) % 16, 3, 0, 0, 0);
        end
        for (int i = 0; i < 16; i++) begin
            drive("R2", 1, i, 4, 0, 0, 0);
        end
        @(negedge clk);
        @(negedge clk);
        chk("R7", "scoreboard drained", sbq.size(), 0);
        finish_run();
    end

endmodule